// File: doc/BRIEF.md
# Redirected Interrupt Dispatch Engine

The engine watches a set of interrupt input pins and checks each one against a 64-bit redirection entry supplied by a neighbouring register block. A pin that is pending and unmasked becomes a candidate for delivery. The lowest-numbered candidate is formed into a message and presented on a valid/ready handshake. The message carries the destination, destination mode, delivery mode, vector, polarity and trigger mode. The engine evaluates the candidate set on every cycle, so a service pass is implied whenever an entry changes, a mask is lifted or an end-of-interrupt releases a pin.

Edge-triggered and level-triggered pins are retired differently. An edge pin latches a request on a rising input, and that request is consumed when its message is formed. A level pin is pending only while its input stays asserted. When a level pin is delivered, the engine sets a per-pin in-service flag, exposed for write-back into the entry. That flag holds the pin off until an end-of-interrupt broadcast arrives carrying the entry's vector. In the legacy-controller delivery mode, the vector is taken from an external input rather than from the entry. Pin 0 is folded onto pin 2 before latching.

Top module: `irq_redirect_engine`

## Requirements
- R1: After reset no message is valid and every in-service flag (`remote_irr_o`) reads 0.
- R2: For an edge pin (entry bit 15 = 0), a 0-to-1 input change sets its pending request. The request is cleared only when its message is formed. A falling input does not clear it, and holding the input high produces no further message.
- R3: For a level pin (entry bit 15 = 1), the pending state follows the input. If the input drops before the pin is serviced, no message is produced.
- R4: Forming a message for a level pin sets that pin's bit in `remote_irr_o`. While the bit is set, the pin produces no further message.
- R5: An end-of-interrupt with vector V clears every set `remote_irr_o` bit whose entry vector (bits 7:0) equals V. A non-matching vector leaves the bits unchanged. A level pin that is then still asserted and unmasked is delivered again.
- R6: A pin whose entry mask (bit 16) is 1 is not delivered. Its edge request is kept and is delivered once the mask is cleared.
- R7: A request on input pin 0 is handled as a request on pin 2, using entry 2. Pin 0 itself is never reported.
- R8: When several pins are ready, messages are issued in ascending pin order, one per accepted handshake. Each message stays valid and unchanged while `msg_ready_i` is low.
- R9: The message fields come from the entry of the reported pin: destination from bits 63:56, destination mode from bit 11, delivery mode from bits 10:8, polarity from bit 13, trigger mode from bit 15 and vector from bits 7:0.
- R10: When the delivery mode is 7 (legacy controller), the message vector equals `ext_vector_i` in the cycle the message is formed, not entry bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Interrupt input levels, 1 = asserted |
| entry_i | input | NUM_PINS*64 | Redirection entries, entry n in bits n*64 +: 64 |
| remote_irr_o | output | NUM_PINS | Per-pin in-service flag for level pins, for write-back to entry bit 14 |
| eoi_valid_i | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector_i | input | 8 | Vector carried by the end-of-interrupt broadcast |
| ext_vector_i | input | 8 | Vector supplied by the legacy controller |
| msg_valid_o | output | 1 | Delivery message valid |
| msg_ready_i | input | 1 | Downstream accepts the message |
| msg_pin_o | output | PIN_W | Pin that produced the message |
| msg_dest_o | output | 8 | Destination |
| msg_dest_mode_o | output | 1 | Destination mode |
| msg_dlv_mode_o | output | 3 | Delivery mode |
| msg_vector_o | output | 8 | Vector |
| msg_polarity_o | output | 1 | Polarity |
| msg_trig_o | output | 1 | Trigger mode, 1 = level |

## Verification
The assertions assume that the entries hold 0 in the in-service bit 14, because the engine owns that state. They also assume that `eoi_valid_i` is a one-cycle strobe, and that `msg_ready_i` is meaningful only while a message is valid. The bench writes entries only through a helper that leaves bit 14 clear, and it drives every input on the falling clock edge. It raises `msg_ready_i` for exactly one cycle to accept each message it has checked. Each end-of-interrupt is sent as a single-cycle pulse while no message is pending, so the check that a flag was released by an end-of-interrupt always sees a clean cause.

// File: rtl/irq_redirect_pkg.sv
package irq_redirect_pkg;
  localparam int ENT_W     = 64;
  localparam int F_DEST_LO = 56;
  localparam int F_MASK    = 16;
  localparam int F_TRIG    = 15;
  localparam int F_POL     = 13;
  localparam int F_DMODE   = 11;
  localparam int F_DLV_LO  = 8;

  typedef enum logic [2:0] {
    DLV_FIXED  = 3'd0,
    DLV_LOWPRI = 3'd1,
    DLV_PMI    = 3'd2,
    DLV_NMI    = 3'd4,
    DLV_INIT   = 3'd5,
    DLV_SIPI   = 3'd6,
    DLV_EXTINT = 3'd7
  } dlv_mode_e;

  typedef struct packed {
    logic [7:0] dest;
    logic       dest_mode;
    logic [2:0] dlv;
    logic [7:0] vector;
    logic       pol;
    logic       trig;
  } dlv_msg_t;
endpackage

// File: rtl/irq_pin_latch.sv
module irq_pin_latch #(
  parameter int NUM_PINS   = 24,
  parameter bit REMAP_PIN0 = 1'b1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] take_i,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [NUM_PINS-1:0] eff, lvl_q, edge_q;

  generate
    if (REMAP_PIN0) begin : g_remap
      always_comb begin
        eff    = pin_i;
        eff[2] = pin_i[2] | pin_i[0];
        eff[0] = 1'b0;
      end
    end else begin : g_direct
      assign eff = pin_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      edge_q <= '0;
    end else begin
      lvl_q  <= eff;
      // a fresh rising edge wins over consumption
      edge_q <= (edge_q & ~take_i) | (eff & ~lvl_q);
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pend
    assign pend_o[i] = level_i[i] ? lvl_q[i] : edge_q[i];
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N     = 24,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/irq_remote_irr.sv
module irq_remote_irr #(
  parameter int NUM_PINS = 24
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_PINS-1:0]   set_i,
  input  logic                  eoi_valid_i,
  input  logic [7:0]            eoi_vector_i,
  input  logic [NUM_PINS*8-1:0] vec_i,
  output logic [NUM_PINS-1:0]   rirr_o
);
  logic [NUM_PINS-1:0] clr;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_clr
    assign clr[i] = eoi_valid_i && (vec_i[i*8 +: 8] == eoi_vector_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rirr_o <= '0;
    else         rirr_o <= (rirr_o & ~clr) | set_i;
  end
endmodule

// File: rtl/irq_redirect_engine.sv
module irq_redirect_engine
  import irq_redirect_pkg::*;
#(
  parameter int NUM_PINS   = 24,
  parameter bit REMAP_PIN0 = 1'b1,
  localparam int PIN_W     = $clog2(NUM_PINS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_PINS-1:0]       pin_i,
  input  logic [NUM_PINS*ENT_W-1:0] entry_i,
  output logic [NUM_PINS-1:0]       remote_irr_o,
  input  logic                      eoi_valid_i,
  input  logic [7:0]                eoi_vector_i,
  input  logic [7:0]                ext_vector_i,
  output logic                      msg_valid_o,
  input  logic                      msg_ready_i,
  output logic [PIN_W-1:0]          msg_pin_o,
  output logic [7:0]                msg_dest_o,
  output logic                      msg_dest_mode_o,
  output logic [2:0]                msg_dlv_mode_o,
  output logic [7:0]                msg_vector_o,
  output logic                      msg_polarity_o,
  output logic                      msg_trig_o
);
  logic [NUM_PINS-1:0]   mask_v, level_v, pend, cand, take;
  logic [NUM_PINS*8-1:0] vec_v;
  logic                  any, load, vld_q;
  logic [PIN_W-1:0]      sel, pin_q;
  logic [ENT_W-1:0]      ent_sel;
  dlv_msg_t              msg_d, msg_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_fields
    assign mask_v[i]       = entry_i[i*ENT_W + F_MASK];
    assign level_v[i]      = entry_i[i*ENT_W + F_TRIG];
    assign vec_v[i*8 +: 8] = entry_i[i*ENT_W +: 8];
  end

  irq_pin_latch #(.NUM_PINS(NUM_PINS), .REMAP_PIN0(REMAP_PIN0)) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .level_i (level_v),
    .take_i  (take),
    .pend_o  (pend)
  );

  assign cand = pend & ~mask_v & ~(level_v & remote_irr_o);

  irq_prio_pick #(.N(NUM_PINS)) u_pick (
    .req_i (cand),
    .any_o (any),
    .idx_o (sel)
  );

  assign load = any && (!vld_q || msg_ready_i);
  assign take = load ? (NUM_PINS'(1) << sel) : '0;

  irq_remote_irr #(.NUM_PINS(NUM_PINS)) u_rirr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .set_i        (take & level_v),
    .eoi_valid_i  (eoi_valid_i),
    .eoi_vector_i (eoi_vector_i),
    .vec_i        (vec_v),
    .rirr_o       (remote_irr_o)
  );

  assign ent_sel = entry_i[sel*ENT_W +: ENT_W];

  always_comb begin
    msg_d.dest      = ent_sel[F_DEST_LO +: 8];
    msg_d.dest_mode = ent_sel[F_DMODE];
    msg_d.dlv       = ent_sel[F_DLV_LO +: 3];
    msg_d.pol       = ent_sel[F_POL];
    msg_d.trig      = ent_sel[F_TRIG];
    msg_d.vector    = (ent_sel[F_DLV_LO +: 3] == DLV_EXTINT) ? ext_vector_i : ent_sel[7:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      pin_q <= '0;
      msg_q <= '0;
    end else if (load) begin
      vld_q <= 1'b1;
      pin_q <= sel;
      msg_q <= msg_d;
    end else if (msg_ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign msg_valid_o     = vld_q;
  assign msg_pin_o       = pin_q;
  assign msg_dest_o      = msg_q.dest;
  assign msg_dest_mode_o = msg_q.dest_mode;
  assign msg_dlv_mode_o  = msg_q.dlv;
  assign msg_vector_o    = msg_q.vector;
  assign msg_polarity_o  = msg_q.pol;
  assign msg_trig_o      = msg_q.trig;
endmodule

// File: rtl/irq_redirect_engine_chk.sv
module irq_redirect_engine_chk #(
  parameter int NUM_PINS   = 24,
  parameter bit REMAP_PIN0 = 1'b1,
  localparam int PIN_W     = $clog2(NUM_PINS)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [NUM_PINS*64-1:0] entry_i,
  input logic [NUM_PINS-1:0]    remote_irr_o,
  input logic                   eoi_valid_i,
  input logic                   msg_valid_o,
  input logic                   msg_ready_i,
  input logic [PIN_W-1:0]       msg_pin_o,
  input logic [7:0]             msg_dest_o,
  input logic                   msg_dest_mode_o,
  input logic [2:0]             msg_dlv_mode_o,
  input logic [7:0]             msg_vector_o,
  input logic                   msg_polarity_o,
  input logic                   msg_trig_o
);
  logic [NUM_PINS-1:0] mask_now, mask_q;
  logic vld_q, rdy_q, new_msg;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_m
    assign mask_now[i] = entry_i[i*64 + 16];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      vld_q  <= 1'b0;
      rdy_q  <= 1'b0;
    end else begin
      mask_q <= mask_now;
      vld_q  <= msg_valid_o;
      rdy_q  <= msg_ready_i;
    end
  end

  assign new_msg = msg_valid_o && (!vld_q || rdy_q);

  AST_HOLD_WHILE_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msg_valid_o && !msg_ready_i) |=> (msg_valid_o && $stable({msg_pin_o, msg_dest_o,
      msg_dest_mode_o, msg_dlv_mode_o, msg_vector_o, msg_polarity_o, msg_trig_o}))); // R8

  AST_RIRR_FALL_NEEDS_EOI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(remote_irr_o) & ~remote_irr_o)) |-> $past(eoi_valid_i)); // R5

  AST_RIRR_RISE_NEEDS_LEVEL_MSG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(remote_irr_o & ~$past(remote_irr_o))) |-> (new_msg && msg_trig_o)); // R4

  AST_NO_MASKED_DELIVERY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    new_msg |-> !mask_q[msg_pin_o]); // R6

  generate
    if (REMAP_PIN0) begin : g_remap_chk
      AST_PIN0_NEVER_REPORTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msg_valid_o |-> (msg_pin_o != '0)); // R7
    end
  endgenerate
endmodule

bind irq_redirect_engine irq_redirect_engine_chk #(.NUM_PINS(NUM_PINS), .REMAP_PIN0(REMAP_PIN0)) u_chk (.*);

// File: tb/tb_irq_redirect_engine.sv
module tb_irq_redirect_engine;
  localparam int NP = 8;
  localparam int PW = $clog2(NP);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NP-1:0] pin_i = '0;
  logic [63:0] ent [NP];
  logic [NP*64-1:0] entry_flat;
  logic [NP-1:0] remote_irr_o;
  logic eoi_valid_i = 1'b0;
  logic [7:0] eoi_vector_i = '0;
  logic [7:0] ext_vector_i = '0;
  logic msg_valid_o;
  logic msg_ready_i = 1'b0;
  logic [PW-1:0] msg_pin_o;
  logic [7:0] msg_dest_o, msg_vector_o;
  logic msg_dest_mode_o, msg_polarity_o, msg_trig_o;
  logic [2:0] msg_dlv_mode_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #5 clk_i = ~clk_i;

  always_comb for (int i = 0; i < NP; i++) entry_flat[i*64 +: 64] = ent[i];

  irq_redirect_engine #(.NUM_PINS(NP), .REMAP_PIN0(1'b1)) dut (
    .clk_i, .rst_ni, .pin_i, .entry_i(entry_flat), .remote_irr_o,
    .eoi_valid_i, .eoi_vector_i, .ext_vector_i, .msg_valid_o, .msg_ready_i,
    .msg_pin_o, .msg_dest_o, .msg_dest_mode_o, .msg_dlv_mode_o, .msg_vector_o,
    .msg_polarity_o, .msg_trig_o
  );

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  function automatic logic [63:0] mk(int dest, bit msk, bit lvl, bit pol, bit dmd, int dm, int vec);
    logic [63:0] e = '0;
    e[63:56] = dest[7:0]; e[16] = msk; e[15] = lvl; e[13] = pol;
    e[11] = dmd; e[10:8] = dm[2:0]; e[7:0] = vec[7:0];
    return e;
  endfunction

  task automatic chk(string req, string what, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic accept();
    msg_ready_i = 1'b1; step(1); msg_ready_i = 1'b0;
  endtask

  task automatic expect_msg(string req, int pin, logic [63:0] e, logic [7:0] extv);
    logic [7:0] evec;
    for (int k = 0; k < 12 && !msg_valid_o; k++) step(1);
    chk(req, "valid", msg_valid_o, 1);
    evec = (e[10:8] == 3'd7) ? extv : e[7:0];
    chk(req, "pin", msg_pin_o, pin);
    chk(req, "vector", msg_vector_o, evec);
    chk(req, "fields", {msg_dest_o, msg_dest_mode_o, msg_dlv_mode_o, msg_polarity_o, msg_trig_o},
        {e[63:56], e[11], e[10:8], e[13], e[15]});
    accept();
  endtask

  task automatic expect_none(string req, int n);
    step(n);
    chk(req, "no message", msg_valid_o, 0);
  endtask

  task automatic eoi(int v);
    eoi_vector_i = v[7:0]; eoi_valid_i = 1'b1; step(1); eoi_valid_i = 1'b0; step(2);
  endtask

  initial begin
    for (int i = 0; i < NP; i++) ent[i] = mk(0, 1, 0, 0, 0, 0, 0);
    step(3);
    rst_ni = 1'b1;
    step(2);
    // R1
    chk("R1", "valid after reset", msg_valid_o, 0);
    chk("R1", "remote_irr after reset", remote_irr_o, 0);

    // R2: edge latch, no repeat while held, re-arm on new rise
    ent[3] = mk(8'h12, 0, 0, 0, 0, 0, 8'h40);
    pin_i[3] = 1'b1;
    expect_msg("R2", 3, ent[3], 0);
    expect_none("R2", 6);
    pin_i[3] = 1'b0; expect_none("R2", 4);
    pin_i[3] = 1'b1;
    expect_msg("R2", 3, ent[3], 0);
    pin_i[3] = 1'b0; step(2);

    // R6 + R2: masked edge request survives falling input
    ent[5] = mk(8'h05, 1, 0, 1, 1, 1, 8'h55);
    pin_i[5] = 1'b1; step(2); pin_i[5] = 1'b0;
    expect_none("R6", 6);
    ent[5][16] = 1'b0;
    expect_msg("R6", 5, ent[5], 0);
    expect_none("R6", 4);

    // R7: pin 0 folded onto pin 2
    ent[2] = mk(8'h22, 0, 0, 0, 0, 0, 8'h22);
    ent[0] = mk(8'h99, 0, 0, 0, 0, 0, 8'h99);
    pin_i[0] = 1'b1;
    expect_msg("R7", 2, ent[2], 0);
    pin_i[0] = 1'b0;
    expect_none("R7", 4);
    ent[0][16] = 1'b1;

    // R4 / R5: level hold-off and vector-matched release
    ent[4] = mk(8'h44, 0, 1, 0, 0, 0, 8'h61);
    pin_i[4] = 1'b1;
    expect_msg("R4", 4, ent[4], 0);
    chk("R4", "remote_irr set", remote_irr_o[4], 1);
    expect_none("R4", 8);
    eoi(8'h62);
    chk("R5", "wrong vector keeps flag", remote_irr_o[4], 1);
    expect_none("R5", 4);
    eoi(8'h61);
    expect_msg("R5", 4, ent[4], 0);
    chk("R5", "flag set again", remote_irr_o[4], 1);
    pin_i[4] = 1'b0;
    step(1);
    eoi(8'h61);
    chk("R5", "flag cleared", remote_irr_o[4], 0);
    expect_none("R3", 4);

    // R3: level pulse while masked is forgotten
    ent[4][16] = 1'b1;
    pin_i[4] = 1'b1; step(3); pin_i[4] = 1'b0; step(3);
    ent[4][16] = 1'b0;
    expect_none("R3", 6);
    chk("R3", "flag stays clear", remote_irr_o[4], 0);
    ent[4][16] = 1'b1;

    // R8: ascending order, stall holds message
    ent[1] = mk(8'h01, 0, 0, 0, 0, 0, 8'h31);
    ent[3] = mk(8'h03, 0, 0, 0, 0, 0, 8'h33);
    ent[6] = mk(8'h06, 0, 0, 0, 0, 0, 8'h36);
    pin_i[1] = 1'b1; pin_i[3] = 1'b1; pin_i[6] = 1'b1;
    step(6);
    chk("R8", "first valid", msg_valid_o, 1);
    chk("R8", "stalled pin", msg_pin_o, 1);
    step(4);
    chk("R8", "held pin", msg_pin_o, 1);
    chk("R8", "held vector", msg_vector_o, 8'h31);
    expect_msg("R8", 1, ent[1], 0);
    expect_msg("R8", 3, ent[3], 0);
    expect_msg("R8", 6, ent[6], 0);
    expect_none("R8", 4);
    pin_i = '0; ent[3][16] = 1'b1; ent[6][16] = 1'b1; step(2);

    // R9: field sweep on pin 1
    for (int dm = 0; dm < 7; dm++)
      for (int dmd = 0; dmd < 2; dmd++)
        for (int pol = 0; pol < 2; pol++) begin
          ent[1] = mk(dm * 37 + dmd * 5 + pol, 0, 0, pol[0], dmd[0], dm, dm * 16 + dmd * 4 + pol + 8);
          pin_i[1] = 1'b1;
          expect_msg("R9", 1, ent[1], 0);
          pin_i[1] = 1'b0; step(1);
        end

    // R10: legacy-controller vector sweep on pin 7
    ent[7] = mk(8'h77, 0, 0, 0, 0, 7, 8'h0F);
    for (int v = 0; v < 16; v++) begin
      ext_vector_i = 8'(v * 17);
      pin_i[7] = 1'b1;
      expect_msg("R10", 7, ent[7], ext_vector_i);
      pin_i[7] = 1'b0; step(1);
    end

    expect_none("R2", 4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule